// File: doc/BRIEF.md
# I2C Master Control and Status Register File

This block is the byte-wide register front-end of an I2C master controller. It sits between a host I/O bus and a byte-level bus engine. Six registers sit at offsets 0 to 5 of a small address window: the data byte, the transfer status, a bus-activity register, the main control register, the own slave address and the enable/clock-divider register. Offsets 6 and 7 are unused.

The bus engine never writes registers directly. Instead it reports what happened through single-cycle event inputs. These events set status flags, load received bytes and acknowledge START and STOP requests. The host clears the error-type flags by writing ones to them. START and STOP requests are set by the host and cleared by the engine.

While the enable bit is low, the main control register is held at zero and ignores writes. Software can therefore probe for the controller purely by readback: the divider register returns what was written, and the control register returns zero until the enable bit is set.

Top module: `i2cm_regfile`

## Requirements
- R1: After reset every register reads 0x00 and every engine-facing output is 0.
- R2: A read of offset 0..5 returns data, status, bus-activity, control, own address and enable/divider respectively. The enable/divider register keeps all 8 bits, so a write of 0x70 reads back 0x70. Offsets 6 and 7 read 0x00, and writes to them change nothing.
- R3: Status bit positions are: bit 6 data-ready, bit 5 bus error, bit 4 negative acknowledge, bit 3 stall-after-start and bit 1 master. The other status bits read 0. A pulse on the matching event input sets the bus-error, NACK and stall flags.
- R4: Writing status with a 1 in bit 5, 4 or 3 clears that flag. A 0 leaves it unchanged. Written values in bits 6 and 1 have no effect.
- R5: When an engine event sets a flag in the same cycle that a host write-one clears it, the flag ends up set.
- R6: Bus-activity bit 1 (busy) is set by an acknowledged START and cleared by writing 1 to that bit. The other bits of this register read 0.
- R7: While enable/divider bit 0 is 0, the control register reads 0x00, writes to it are ignored, and its outputs are 0. Clearing the enable bit zeroes the control register. When enabled, control bits 7 (stall enable), 6 (interrupt enable) and 4 (ACK control) are read/write. Control bits 5, 3 and 2 read 0.
- R8: Writing 1 to control bit 0 (START) or bit 1 (STOP) sets that request, and writing 0 does not clear it. An engine START-done pulse clears bit 0 and a STOP-done pulse clears bit 1. A host set in the same cycle as the matching done pulse leaves the request set.
- R9: Status master (bit 1) is set by START-done and cleared by STOP-done. START-done wins if both arrive in the same cycle.
- R10: Data-ready is set by the data-ready event or by a received byte. It is cleared by a host read or write of offset 0. An engine set in the same cycle wins over the clear.
- R11: A host write to offset 0 loads the transmit byte and raises tx_load for exactly the next cycle. A received byte loads offset 0, and it wins over a host write in the same cycle.
- R12: The own-address register reads back as written. Its bits 6:0 drive slave_addr. slave_match_en is 1 exactly when the register is nonzero.
- R13: core_en follows enable/divider bit 0 and scl_div follows bits 7:1. ack_ctl, irq_en and stall_en follow control bits 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_sel | input | 1 | Host access select |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | ADDR_W | Register offset |
| hb_wdata | input | DATA_W | Host write data |
| hb_rdata | output | DATA_W | Read data; 0 when no read is in progress |
| ev_data_ready | input | 1 | Engine: byte slot ready |
| ev_rx_valid | input | 1 | Engine: received byte valid |
| ev_rx_byte | input | DATA_W | Engine: received byte |
| ev_bus_err | input | 1 | Engine: bus error seen |
| ev_nack | input | 1 | Engine: negative acknowledge seen |
| ev_stall | input | 1 | Engine: stalled after start |
| ev_start_done | input | 1 | Engine: START issued |
| ev_stop_done | input | 1 | Engine: STOP issued |
| tx_byte | output | DATA_W | Data register contents |
| tx_load | output | 1 | One-cycle pulse after a host data write |
| core_en | output | 1 | Controller enable |
| scl_div | output | DATA_W-1 | Clock-divider setting |
| start_req | output | 1 | Pending START request |
| stop_req | output | 1 | Pending STOP request |
| ack_ctl | output | 1 | ACK control bit |
| stall_en | output | 1 | Stall-after-start enable |
| irq_en | output | 1 | Interrupt enable |
| slave_addr | output | DATA_W-1 | Own slave address |
| slave_match_en | output | 1 | Slave address matching enabled |

## Verification
The bench builds the block with its defaults: an 8-bit data path, a 3-bit offset and a two-stage reset synchronizer. The 3-bit offset puts the two unused offsets 6 and 7 within reach, so the bench can check that they read zero and that writes to them are ignored. Random host traffic mixes with random engine event pulses. This regularly lands host clears, START/STOP writes and data accesses in the same cycle as the engine events that compete with them. It also turns the enable bit off and on mid-stream, so the control-register gating is exercised while requests are pending.

// File: rtl/i2cm_rf_pkg.sv
package i2cm_rf_pkg;

  // Register offsets within the host window
  localparam int unsigned OFS_DATA  = 0;
  localparam int unsigned OFS_STAT  = 1;
  localparam int unsigned OFS_CSTAT = 2;
  localparam int unsigned OFS_CTL1  = 3;
  localparam int unsigned OFS_OWN   = 4;
  localparam int unsigned OFS_CTL2  = 5;
  localparam int unsigned NUM_REGS  = 6;

  // Status bit positions
  localparam int unsigned ST_DRDY  = 6;
  localparam int unsigned ST_BERR  = 5;
  localparam int unsigned ST_NAK   = 4;
  localparam int unsigned ST_STALL = 3;
  localparam int unsigned ST_MST   = 1;

  // Bus-activity register
  localparam int unsigned CS_BUSY = 1;

  // Control register bit positions
  localparam int unsigned C1_STEN  = 7;
  localparam int unsigned C1_IRQEN = 6;
  localparam int unsigned C1_ACK   = 4;
  localparam int unsigned C1_STOP  = 1;
  localparam int unsigned C1_START = 0;

  // Enable/divider register
  localparam int unsigned C2_EN = 0;

  // Number of write-one-to-clear status flags
  localparam int unsigned NUM_W1C = 3;

  typedef struct packed {
    logic stall_en;
    logic irq_en;
    logic ack;
    logic stop;
    logic start;
  } ctl1_t;

endpackage

// File: rtl/i2cm_rf_decode.sv
module i2cm_rf_decode #(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] wr_hit_o,
  output logic [NUM_REGS-1:0] rd_hit_o
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    logic match;
    assign match       = sel_i && (addr_i == ADDR_W'(i));
    assign wr_hit_o[i] = match && wr_i;
    assign rd_hit_o[i] = match && rd_i;
  end

endmodule

// File: rtl/i2cm_rf_flag.sv
module i2cm_rf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  logic q_r;
  logic q_d;
  logic q_en;

  // Set has priority over clear
  always_comb begin
    q_en = set_i || clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  assert_flag_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));

endmodule

// File: rtl/i2cm_rf_ctrl.sv
module i2cm_rf_ctrl
  import i2cm_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_c1_i,
  input  logic              wr_c2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_ack_i,
  input  logic              stop_ack_i,
  output logic [DATA_W-1:0] c1_view_o,
  output logic [DATA_W-1:0] c2_view_o
);

  ctl1_t             c1_q, c1_d;
  logic              c1_en;
  logic [DATA_W-1:0] c2_q, c2_d;
  logic              c2_en;
  logic              en_next;
  logic              host_start, host_stop;

  always_comb begin
    c2_en   = wr_c2_i;
    c2_d    = wdata_i;
    en_next = wr_c2_i ? wdata_i[C2_EN] : c2_q[C2_EN];

    host_start = wr_c1_i && wdata_i[C1_START];
    host_stop  = wr_c1_i && wdata_i[C1_STOP];

    c1_d = c1_q;
    if (wr_c1_i) begin
      c1_d.stall_en = wdata_i[C1_STEN];
      c1_d.irq_en   = wdata_i[C1_IRQEN];
      c1_d.ack      = wdata_i[C1_ACK];
    end
    // Requests: host set wins, engine acknowledge clears
    if (host_start)       c1_d.start = 1'b1;
    else if (start_ack_i) c1_d.start = 1'b0;
    if (host_stop)        c1_d.stop  = 1'b1;
    else if (stop_ack_i)  c1_d.stop  = 1'b0;
    // Disabled controller keeps the control register at zero
    if (!en_next) c1_d = '0;

    c1_en = wr_c1_i || wr_c2_i || start_ack_i || stop_ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= '0;
    end else if (c1_en) begin
      c1_q <= c1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_q <= '0;
    end else if (c2_en) begin
      c2_q <= c2_d;
    end
  end

  always_comb begin
    c1_view_o           = '0;
    c1_view_o[C1_STEN]  = c1_q.stall_en;
    c1_view_o[C1_IRQEN] = c1_q.irq_en;
    c1_view_o[C1_ACK]   = c1_q.ack;
    c1_view_o[C1_STOP]  = c1_q.stop;
    c1_view_o[C1_START] = c1_q.start;
  end

  assign c2_view_o = c2_q;

  assert_ctl1_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !c2_q[C2_EN] |-> (c1_view_o == '0));

  assert_start_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ack_i && !host_start) |=> !c1_q.start);

  assert_start_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_start && c2_q[C2_EN]) |=> c1_q.start);

  assert_stop_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stop && c2_q[C2_EN]) |=> c1_q.stop);

endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
  import i2cm_rf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_sel,
  input  logic              hb_wr,
  input  logic              hb_rd,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_wdata,
  output logic [DATA_W-1:0] hb_rdata,
  input  logic              ev_data_ready,
  input  logic              ev_rx_valid,
  input  logic [DATA_W-1:0] ev_rx_byte,
  input  logic              ev_bus_err,
  input  logic              ev_nack,
  input  logic              ev_stall,
  input  logic              ev_start_done,
  input  logic              ev_stop_done,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_load,
  output logic              core_en,
  output logic [DATA_W-2:0] scl_div,
  output logic              start_req,
  output logic              stop_req,
  output logic              ack_ctl,
  output logic              stall_en,
  output logic              irq_en,
  output logic [DATA_W-2:0] slave_addr,
  output logic              slave_match_en
);

  localparam int unsigned W1C_POS [NUM_W1C] = '{ST_BERR, ST_NAK, ST_STALL};

  // Reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  // Offset decode
  logic [NUM_REGS-1:0] wr_hit, rd_hit;

  i2cm_rf_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .sel_i    (hb_sel),
    .wr_i     (hb_wr),
    .rd_i     (hb_rd),
    .addr_i   (hb_addr),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  // Data register and transmit-load pulse
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;
  logic              txl_q, txl_d;

  always_comb begin
    data_en = ev_rx_valid || wr_hit[OFS_DATA];
    data_d  = ev_rx_valid ? ev_rx_byte : hb_wdata;
    txl_d   = wr_hit[OFS_DATA];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      txl_q <= 1'b0;
    end else begin
      txl_q <= txl_d;
    end
  end

  // Status flags
  logic               drdy_q, mst_q, busy_q;
  logic [NUM_W1C-1:0] w1c_set, w1c_q;

  i2cm_rf_flag u_drdy (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ev_data_ready || ev_rx_valid),
    .clr_i (wr_hit[OFS_DATA] || rd_hit[OFS_DATA]),
    .q_o   (drdy_q)
  );

  i2cm_rf_flag u_master (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ev_start_done),
    .clr_i (ev_stop_done),
    .q_o   (mst_q)
  );

  i2cm_rf_flag u_busy (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (ev_start_done),
    .clr_i (wr_hit[OFS_CSTAT] && hb_wdata[CS_BUSY]),
    .q_o   (busy_q)
  );

  assign w1c_set = {ev_stall, ev_nack, ev_bus_err};

  for (genvar g = 0; g < NUM_W1C; g++) begin : g_w1c
    i2cm_rf_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (w1c_set[g]),
      .clr_i (wr_hit[OFS_STAT] && hb_wdata[W1C_POS[g]]),
      .q_o   (w1c_q[g])
    );
  end

  // Control and enable/divider registers
  logic [DATA_W-1:0] c1_view, c2_view;

  i2cm_rf_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_c1_i     (wr_hit[OFS_CTL1]),
    .wr_c2_i     (wr_hit[OFS_CTL2]),
    .wdata_i     (hb_wdata),
    .start_ack_i (ev_start_done),
    .stop_ack_i  (ev_stop_done),
    .c1_view_o   (c1_view),
    .c2_view_o   (c2_view)
  );

  // Own address register
  logic [DATA_W-1:0] own_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      own_q <= '0;
    end else if (wr_hit[OFS_OWN]) begin
      own_q <= hb_wdata;
    end
  end

  // Read views and read mux
  logic [DATA_W-1:0] reg_view [NUM_REGS];
  logic [DATA_W-1:0] stat_view, cstat_view;

  always_comb begin
    stat_view          = '0;
    stat_view[ST_DRDY] = drdy_q;
    stat_view[ST_MST]  = mst_q;
    for (int k = 0; k < NUM_W1C; k++) begin
      stat_view[W1C_POS[k]] = w1c_q[k];
    end
    cstat_view          = '0;
    cstat_view[CS_BUSY] = busy_q;
  end

  always_comb begin
    reg_view[OFS_DATA]  = data_q;
    reg_view[OFS_STAT]  = stat_view;
    reg_view[OFS_CSTAT] = cstat_view;
    reg_view[OFS_CTL1]  = c1_view;
    reg_view[OFS_OWN]   = own_q;
    reg_view[OFS_CTL2]  = c2_view;
  end

  always_comb begin
    hb_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_hit[i]) hb_rdata = hb_rdata | reg_view[i];
    end
  end

  // Engine-facing outputs
  assign tx_byte        = data_q;
  assign tx_load        = txl_q;
  assign core_en        = c2_view[C2_EN];
  assign scl_div        = c2_view[DATA_W-1:1];
  assign start_req      = c1_view[C1_START];
  assign stop_req       = c1_view[C1_STOP];
  assign ack_ctl        = c1_view[C1_ACK];
  assign irq_en         = c1_view[C1_IRQEN];
  assign stall_en       = c1_view[C1_STEN];
  assign slave_addr     = own_q[DATA_W-2:0];
  assign slave_match_en = |own_q;

  assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(wr_hit));

  assert_master_on_start_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_start_done |=> hb_sel && hb_rd && (hb_addr == ADDR_W'(OFS_STAT)) |-> hb_rdata[ST_MST]);

  assert_master_off_stop_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_stop_done && !ev_start_done) |=> !mst_q);

  assert_tx_load_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit[OFS_DATA] && !ev_rx_valid) |=> (tx_load && tx_byte == $past(hb_wdata)));

  assert_rx_wins_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_rx_valid |=> (tx_byte == $past(ev_rx_byte)));

  assert_own_match_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hit[OFS_OWN] |=> (slave_match_en == ($past(hb_wdata) != '0)));

endmodule

// File: tb/i2cm_regfile_bench.sv
module i2cm_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       hb_sel = 0, hb_wr = 0, hb_rd = 0;
  logic [2:0] hb_addr = 0;
  logic [7:0] hb_wdata = 0;
  logic [7:0] hb_rdata;
  logic       ev_data_ready = 0, ev_rx_valid = 0, ev_bus_err = 0, ev_nack = 0;
  logic       ev_stall = 0, ev_start_done = 0, ev_stop_done = 0;
  logic [7:0] ev_rx_byte = 0;
  logic [7:0] tx_byte;
  logic       tx_load, core_en, start_req, stop_req, ack_ctl, stall_en, irq_en;
  logic [6:0] scl_div, slave_addr;
  logic       slave_match_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] m_data = 0, m_c1 = 0, m_c2 = 0, m_own = 0;
  logic       m_dr = 0, m_ber = 0, m_nak = 0, m_stl = 0, m_mst = 0, m_busy = 0, m_txl = 0;
  logic [7:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cm_regfile u_i2cm_regfile (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr), .hb_rd(hb_rd),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
    .ev_data_ready(ev_data_ready), .ev_rx_valid(ev_rx_valid), .ev_rx_byte(ev_rx_byte),
    .ev_bus_err(ev_bus_err), .ev_nack(ev_nack), .ev_stall(ev_stall),
    .ev_start_done(ev_start_done), .ev_stop_done(ev_stop_done),
    .tx_byte(tx_byte), .tx_load(tx_load), .core_en(core_en), .scl_div(scl_div),
    .start_req(start_req), .stop_req(stop_req), .ack_ctl(ack_ctl), .stall_en(stall_en),
    .irq_en(irq_en), .slave_addr(slave_addr), .slave_match_en(slave_match_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_data;
      3'd1: return {1'b0, m_dr, m_ber, m_nak, m_stl, 1'b0, m_mst, 1'b0};
      3'd2: return {6'b0, m_busy, 1'b0};
      3'd3: return m_c1;
      3'd4: return m_own;
      3'd5: return m_c2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_update();
    logic       w, r;
    logic [7:0] c2n, c1n;
    w = hb_sel && hb_wr;
    r = hb_sel && hb_rd;
    m_txl = w && hb_addr == 3'd0;
    if (w && hb_addr == 3'd1) begin
      if (hb_wdata[5]) m_ber = 1'b0;
      if (hb_wdata[4]) m_nak = 1'b0;
      if (hb_wdata[3]) m_stl = 1'b0;
    end
    if (ev_bus_err) m_ber = 1'b1;
    if (ev_nack)    m_nak = 1'b1;
    if (ev_stall)   m_stl = 1'b1;
    if ((w || r) && hb_addr == 3'd0) m_dr = 1'b0;
    if (ev_data_ready || ev_rx_valid) m_dr = 1'b1;
    if (ev_rx_valid) m_data = ev_rx_byte;
    else if (w && hb_addr == 3'd0) m_data = hb_wdata;
    if (ev_start_done) m_mst = 1'b1;
    else if (ev_stop_done) m_mst = 1'b0;
    if (w && hb_addr == 3'd2 && hb_wdata[1]) m_busy = 1'b0;
    if (ev_start_done) m_busy = 1'b1;
    c2n = (w && hb_addr == 3'd5) ? hb_wdata : m_c2;
    c1n = m_c1;
    if (w && hb_addr == 3'd3) c1n = (c1n & 8'h03) | (hb_wdata & 8'hD0);
    c1n[0] = (w && hb_addr == 3'd3 && hb_wdata[0]) ? 1'b1 : (ev_start_done ? 1'b0 : m_c1[0]);
    c1n[1] = (w && hb_addr == 3'd3 && hb_wdata[1]) ? 1'b1 : (ev_stop_done ? 1'b0 : m_c1[1]);
    if (!c2n[0]) c1n = 8'h00;
    m_c1 = c1n;
    m_c2 = c2n;
    if (w && hb_addr == 3'd4) m_own = hb_wdata;
  endtask

  task automatic check_outputs();
    chk("R11 tx_byte", tx_byte, m_data);
    chk("R11 tx_load", tx_load, m_txl);
    chk("R13 core_en", core_en, m_c2[0]);
    chk("R13 scl_div", scl_div, m_c2[7:1]);
    chk("R8 start_req", start_req, m_c1[0]);
    chk("R8 stop_req", stop_req, m_c1[1]);
    chk("R13 ack_ctl", ack_ctl, m_c1[4]);
    chk("R13 irq_en", irq_en, m_c1[6]);
    chk("R13 stall_en", stall_en, m_c1[7]);
    chk("R12 slave_addr", slave_addr, m_own[6:0]);
    chk("R12 slave_match_en", slave_match_en, m_own != 8'h00);
  endtask

  task automatic idle_inputs();
    hb_sel = 0; hb_wr = 0; hb_rd = 0; hb_addr = 0; hb_wdata = 0;
    ev_data_ready = 0; ev_rx_valid = 0; ev_rx_byte = 0; ev_bus_err = 0;
    ev_nack = 0; ev_stall = 0; ev_start_done = 0; ev_stop_done = 0;
  endtask

  // Called at a negedge with inputs already set
  task automatic step();
    #1;
    last_rd = hb_rdata;
    if (hb_sel && hb_rd) chk("R2 readback", hb_rdata, exp_read(hb_addr));
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_inputs();
    check_outputs();
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    hb_sel = 1; hb_wr = 1; hb_addr = a; hb_wdata = d;
    step();
  endtask

  task automatic rd_lit(input logic [2:0] a, input logic [7:0] exp, input string tag);
    hb_sel = 1; hb_rd = 1; hb_addr = a;
    step();
    chk(tag, last_rd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_outputs();
    for (int a = 0; a < 8; a++) rd_lit(3'(a), 8'h00, "R1 reset read");

    // R2: divider readback, disabled controller
    wr_reg(3'd5, 8'h70);
    rd_lit(3'd5, 8'h70, "R2 ctl2 0x70 readback");
    chk("R13 scl_div 0x38", scl_div, 7'h38);
    // R7: write while disabled ignored
    wr_reg(3'd3, 8'h40);
    rd_lit(3'd3, 8'h00, "R7 ctl1 zero while disabled");
    chk("R7 irq_en off while disabled", irq_en, 1'b0);
    // Enable and set fields
    wr_reg(3'd5, 8'h71);
    wr_reg(3'd3, 8'h40);
    rd_lit(3'd3, 8'h40, "R7 irq_en sticks when enabled");
    wr_reg(3'd3, 8'hFC);
    rd_lit(3'd3, 8'hD0, "R7 unused ctl1 bits read 0");

    // R8: START set, write 0 does not clear, ack clears
    wr_reg(3'd3, 8'hD1);
    rd_lit(3'd3, 8'hD1, "R8 start set");
    wr_reg(3'd3, 8'hD0);
    rd_lit(3'd3, 8'hD1, "R8 start kept by zero write");
    ev_start_done = 1; step();
    rd_lit(3'd3, 8'hD0, "R8 start cleared by ack");
    rd_lit(3'd1, 8'h02, "R9 master set by start");
    rd_lit(3'd2, 8'h02, "R6 busy set by start");
    // R8: host set wins over same-cycle ack
    hb_sel = 1; hb_wr = 1; hb_addr = 3'd3; hb_wdata = 8'hD1; ev_start_done = 1;
    step();
    chk("R8 host set wins", start_req, 1'b1);
    wr_reg(3'd3, 8'hD2);
    ev_start_done = 1; ev_stop_done = 1; step();
    chk("R8 both acks clear requests", {start_req, stop_req}, 2'b00);
    chk("R9 start wins over stop", exp_read(3'd1) & 8'h02, 8'h02);
    rd_lit(3'd1, 8'h02, "R9 master held");
    // R6: busy W1C, R9: stop clears master
    wr_reg(3'd2, 8'h02);
    rd_lit(3'd2, 8'h00, "R6 busy cleared");
    ev_stop_done = 1; step();
    rd_lit(3'd1, 8'h00, "R9 master cleared by stop");

    // R3 / R4: W1C flags
    ev_bus_err = 1; ev_nack = 1; ev_stall = 1; step();
    rd_lit(3'd1, 8'h38, "R3 flag positions");
    wr_reg(3'd1, 8'h10);
    rd_lit(3'd1, 8'h28, "R4 nack cleared");
    wr_reg(3'd1, 8'h00);
    rd_lit(3'd1, 8'h28, "R4 zero write keeps flags");
    wr_reg(3'd1, 8'h42);
    rd_lit(3'd1, 8'h28, "R4 bits 6 and 1 ignored");
    wr_reg(3'd1, 8'h28);
    rd_lit(3'd1, 8'h00, "R4 remaining flags cleared");
    // R5: engine set wins
    hb_sel = 1; hb_wr = 1; hb_addr = 3'd1; hb_wdata = 8'h10; ev_nack = 1;
    step();
    rd_lit(3'd1, 8'h10, "R5 set wins over clear");
    wr_reg(3'd1, 8'h10);

    // R10 / R11: data path
    ev_rx_valid = 1; ev_rx_byte = 8'hA5; step();
    rd_lit(3'd1, 8'h40, "R10 data-ready on rx");
    rd_lit(3'd0, 8'hA5, "R11 rx byte loaded");
    rd_lit(3'd1, 8'h00, "R10 cleared by data read");
    wr_reg(3'd0, 8'h3C);
    chk("R11 tx_load pulse", tx_load, 1'b1);
    chk("R11 tx_byte", tx_byte, 8'h3C);
    step();
    chk("R11 tx_load one cycle", tx_load, 1'b0);
    hb_sel = 1; hb_wr = 1; hb_addr = 3'd0; hb_wdata = 8'h11; ev_data_ready = 1;
    step();
    rd_lit(3'd1, 8'h40, "R10 engine set wins over write");
    hb_sel = 1; hb_wr = 1; hb_addr = 3'd0; hb_wdata = 8'h22;
    ev_rx_valid = 1; ev_rx_byte = 8'h99; step();
    chk("R11 rx wins over host write", tx_byte, 8'h99);

    // R2: unused offsets; R12: own address
    wr_reg(3'd6, 8'hFF);
    wr_reg(3'd7, 8'hFF);
    rd_lit(3'd6, 8'h00, "R2 offset 6 reads 0");
    rd_lit(3'd4, 8'h00, "R2 own untouched by offset 6/7");
    chk("R12 match off at zero", slave_match_en, 1'b0);
    wr_reg(3'd4, 8'h85);
    rd_lit(3'd4, 8'h85, "R12 own readback");
    chk("R12 slave_addr", slave_addr, 7'h05);
    chk("R12 match on", slave_match_en, 1'b1);

    // R7: disabling zeroes control
    wr_reg(3'd3, 8'hD3);
    wr_reg(3'd5, 8'h70);
    rd_lit(3'd3, 8'h00, "R7 disable zeroes ctl1");
    chk("R7 start_req off", start_req, 1'b0);

    // Random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      int op;
      op = $urandom % 3;
      hb_addr  = 3'($urandom % 8);
      hb_wdata = 8'($urandom);
      if (hb_addr == 3'd5) hb_wdata[0] = ($urandom % 4) != 0;
      if (op == 1) begin hb_sel = 1; hb_wr = 1; end
      else if (op == 2) begin hb_sel = 1; hb_rd = 1; end
      ev_data_ready = ($urandom % 8) == 0;
      ev_rx_valid   = ($urandom % 8) == 0;
      ev_rx_byte    = 8'($urandom);
      ev_bus_err    = ($urandom % 8) == 0;
      ev_nack       = ($urandom % 8) == 0;
      ev_stall      = ($urandom % 8) == 0;
      ev_start_done = ($urandom % 8) == 0;
      ev_stop_done  = ($urandom % 8) == 0;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule